// File: doc/BRIEF.md
# Frame-Gated Serial Audio Transmit Lane

This block is one transmit lane of a serial audio port. Software writes a sample word into a holding register. The lane sends that word most significant bit first on a serial data output, one bit for each bit-clock tick. The lane only starts sending at a frame sync. When its enable is cleared, it finishes the word it is sending, then stops driving and floats the data pin. In network mode the lane keeps sending words back to back, one per slot. In that mode, a clear-then-set of the enable during a word keeps the lane silent from the end of that word until the next frame sync. The data pin can be shared with a receiver input, and two enable bits decide which side owns it.

Everything runs on one system clock. `bit_tick` is a one-cycle strobe that marks a bit-clock edge, and `frame_sync` is sampled only when `bit_tick` is high. A controller with three states sequences the lane:

- `LS_OFF`: the lane is disabled and the pin floats.
- `LS_ARMED`: the lane is enabled and waiting for a frame, and the pin floats.
- `LS_SEND`: a word is being shifted out and the pin is driven.

The transitions are:

- OFF→ARMED: on any cycle with the enable set.
- ARMED→OFF: on any cycle with the enable clear.
- ARMED→SEND: on a tick carrying frame sync while enabled.
- SEND→SEND: at the last bit of a word, when a new word is loaded. This happens on a frame sync, or in network mode when no restart is pending.
- SEND→ARMED: at the last bit of a word, when the lane is still enabled but no new word is loaded.
- SEND→OFF: at the last bit of a word, when the enable is clear.

Top module: `fsa_tx_lane`

## Requirements
- R1: After reset, `sd_oe`=0, `sd_out`=0, `tde`=1 (holding register empty), `underrun`=0, `cfg_err`=0 and `rx_sel`=0.
- R2: The enable of this lane is bit `LANE` of `tx_ctrl`. Setting any other bit of `tx_ctrl` never makes the lane drive its pin.
- R3: With the enable set, the lane drives `sd_oe`=1 only from the cycle after a tick that carries `frame_sync`. Before that it stays floated, and `sd_oe` matches a lane that is sending a word.
- R4: A load copies the holding register into the shift register on the frame-sync tick. `sd_out` then shows bit `WORD_W-1` first and moves to the next lower bit on each tick, for `WORD_W` ticks. While `sd_oe`=0, `sd_out` is 0.
- R5: If the enable is cleared in the middle of a word, `sd_oe` stays 1 until that word's last bit has been sent, then goes to 0.
- R6: A holding-register write while the enable is clear is kept (`tde` stays 0) but is never loaded, and the pin stays floated.
- R7: In network mode, words follow each other without a gap at every `WORD_W`-tick boundary. If the enable is cleared and set again during a word, the pin floats from that word's end until the next frame sync.
- R8: `tde` goes to 1 when a load takes the holding register. A write (`wr_en`=1) clears it on the next cycle. If a write and a load fall in the same cycle, the write wins.
- R9: A load with the holding register empty sends an all-zero word and sets the sticky `underrun` flag. `clr_flags` clears the flag.
- R10: With `SHARED_PIN`=1, `rx_sel` is 1 exactly when the lane enable is 0 and `rx_en` is 1. With both clear, neither side owns the pin and `sd_oe`=0.
- R11: If both the lane enable and `rx_en` are set, the transmitter owns the pin (`rx_sel`=0). The sticky `cfg_err` flag is set one cycle later and stays set until `clr_flags` is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_tick | input | 1 | One-cycle strobe marking a bit-clock edge |
| frame_sync | input | 1 | Frame start, sampled only with `bit_tick` |
| net_mode | input | 1 | 1 = back-to-back slot words, 0 = one word per frame |
| tx_ctrl | input | NUM_LANES | Transmit enable bits; this lane uses bit `LANE` |
| rx_en | input | 1 | Receive enable of the receiver sharing the pin |
| wr_en | input | 1 | Holding-register write strobe |
| wr_data | input | WORD_W | Holding-register write data |
| clr_flags | input | 1 | Clears `underrun` and `cfg_err` |
| sd_out | output | 1 | Serial data bit |
| sd_oe | output | 1 | Output enable of the serial data pin |
| rx_sel | output | 1 | Pin is handed to the receiver input |
| tde | output | 1 | Holding register empty |
| underrun | output | 1 | Sticky: a word was sent without new data |
| cfg_err | output | 1 | Sticky: both pin enables were set together |

## Verification
The network-mode restart is the hardest case to reach. It needs a falling and a rising enable, both inside the same word, followed by a gap of at least one slot before the next frame sync. Random toggling of the enable seldom produces that.

A directed sequence reaches it. The bench runs with a frame period of three words, waits until a reference model reports bit 3 of the first word, holds the enable low for two cycles and then sets it again. It then checks every cycle up to the next frame sync for a floated pin.

Long random runs follow in both modes. One of them uses a frame period that is not a multiple of the word length, so frame syncs land in the middle of words and must be ignored there.

// File: rtl/fsa_pkg.sv
package fsa_pkg;

    typedef enum logic [1:0] {
        LS_OFF   = 2'd0,
        LS_ARMED = 2'd1,
        LS_SEND  = 2'd2
    } lane_st_e;

endpackage

// File: rtl/fsa_ctrl.sv
module fsa_ctrl
    import fsa_pkg::*;
#(
    parameter int WORD_W = 24
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_tick,
    input  logic frame_sync,
    input  logic tx_en,
    input  logic net_mode,
    output logic load,
    output logic shift,
    output logic active
);
    localparam int CW = (WORD_W > 2) ? $clog2(WORD_W) : 1;
    localparam logic [CW-1:0] LAST_BIT = CW'(WORD_W - 1);

    lane_st_e        st, st_n;
    logic [CW-1:0]   cnt;
    logic            restart;
    logic            last;

    assign last = (cnt == LAST_BIT);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= LS_OFF;
        else        st <= st_n;
    end

    // next state and strobes
    always_comb begin
        st_n   = st;
        load   = 1'b0;
        shift  = 1'b0;
        active = 1'b0;
        unique case (st)
            LS_OFF: begin
                if (tx_en) st_n = LS_ARMED;
            end
            LS_ARMED: begin
                if (!tx_en) begin
                    st_n = LS_OFF;
                end else if (bit_tick && frame_sync) begin
                    load = 1'b1;
                    st_n = LS_SEND;
                end
            end
            LS_SEND: begin
                active = 1'b1;
                shift  = bit_tick;
                if (bit_tick && last) begin
                    if (tx_en && (frame_sync || (net_mode && !restart))) begin
                        load = 1'b1;
                        st_n = LS_SEND;
                    end else if (tx_en) begin
                        st_n = LS_ARMED;
                    end else begin
                        st_n = LS_OFF;
                    end
                end
            end
            default: st_n = LS_OFF;
        endcase
    end

    // bit counter and restart memory
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt     <= '0;
            restart <= 1'b0;
        end else begin
            if (load)
                cnt <= '0;
            else if (shift)
                cnt <= cnt + CW'(1);
            if (load || st != LS_SEND)
                restart <= 1'b0;
            else if (!tx_en)
                restart <= 1'b1;
        end
    end

    p_start_on_fs_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(active) |-> $past(bit_tick && frame_sync));

    p_stop_on_boundary_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(active) |-> $past(bit_tick && last));

    p_restart_silence_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (active && restart && bit_tick && last && !frame_sync) |=> !active);

endmodule

// File: rtl/fsa_datapath.sv
module fsa_datapath #(
    parameter int WORD_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              load,
    input  logic              shift,
    input  logic              clr_flags,
    output logic              ser_bit,
    output logic              tde,
    output logic              underrun
);
    logic [WORD_W-1:0] hold;
    logic [WORD_W-1:0] sr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold     <= '0;
            sr       <= '0;
            tde      <= 1'b1;
            underrun <= 1'b0;
        end else begin
            if (load)
                sr <= tde ? '0 : hold;
            else if (shift)
                sr <= {sr[WORD_W-2:0], 1'b0};
            if (wr_en) begin
                hold <= wr_data;
                tde  <= 1'b0;
            end else if (load) begin
                tde  <= 1'b1;
            end
            underrun <= (underrun & ~clr_flags) | (load & tde);
        end
    end

    assign ser_bit = sr[WORD_W-1];

    p_tde_on_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !tde);

    p_underrun_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (underrun && !clr_flags) |=> underrun);

    p_zero_word_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (load && tde) |=> !ser_bit);

endmodule

// File: rtl/fsa_pinsel.sv
module fsa_pinsel #(
    parameter bit SHARED_PIN = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tx_en,
    input  logic rx_en,
    input  logic clr_flags,
    input  logic active,
    output logic pin_oe,
    output logic rx_sel,
    output logic cfg_err
);
    assign pin_oe = active;

    if (SHARED_PIN) begin : g_shared
        logic err_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) err_q <= 1'b0;
            else        err_q <= (err_q & ~clr_flags) | (tx_en & rx_en);
        end
        assign rx_sel  = ~tx_en & rx_en;
        assign cfg_err = err_q;

        p_tx_priority_r11: assert property (@(posedge clk) disable iff (!rst_n)
            !(rx_sel && pin_oe && tx_en));

        p_cfg_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
            (tx_en && rx_en) |=> cfg_err);
    end else begin : g_private
        logic unused_rx;
        assign unused_rx = rx_en ^ clr_flags;
        assign rx_sel    = 1'b0;
        assign cfg_err   = 1'b0;
    end

endmodule

// File: rtl/fsa_tx_lane.sv
module fsa_tx_lane #(
    parameter int WORD_W     = 24,
    parameter int NUM_LANES  = 3,
    parameter int LANE       = 2,
    parameter bit SHARED_PIN = 1'b1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bit_tick,
    input  logic                 frame_sync,
    input  logic                 net_mode,
    input  logic [NUM_LANES-1:0] tx_ctrl,
    input  logic                 rx_en,
    input  logic                 wr_en,
    input  logic [WORD_W-1:0]    wr_data,
    input  logic                 clr_flags,
    output logic                 sd_out,
    output logic                 sd_oe,
    output logic                 rx_sel,
    output logic                 tde,
    output logic                 underrun,
    output logic                 cfg_err
);
    logic te, load, shift, active, ser_bit;
    logic unused_ctrl;

    assign te          = tx_ctrl[LANE];
    assign unused_ctrl = ^tx_ctrl;

    fsa_ctrl #(.WORD_W(WORD_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_tick   (bit_tick),
        .frame_sync (frame_sync),
        .tx_en      (te),
        .net_mode   (net_mode),
        .load       (load),
        .shift      (shift),
        .active     (active)
    );

    fsa_datapath #(.WORD_W(WORD_W)) u_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .load      (load),
        .shift     (shift),
        .clr_flags (clr_flags),
        .ser_bit   (ser_bit),
        .tde       (tde),
        .underrun  (underrun)
    );

    fsa_pinsel #(.SHARED_PIN(SHARED_PIN)) u_pin (
        .clk       (clk),
        .rst_n     (rst_n),
        .tx_en     (te),
        .rx_en     (rx_en),
        .clr_flags (clr_flags),
        .active    (active),
        .pin_oe    (sd_oe),
        .rx_sel    (rx_sel),
        .cfg_err   (cfg_err)
    );

    assign sd_out = active & ser_bit;

    p_load_gated_r6: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> te);

    p_float_when_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !sd_oe |-> !sd_out);

endmodule

// File: tb/fsa_tx_lane_test.sv
`timescale 1ns/1ps
module fsa_tx_lane_test;
    localparam int W  = 8;
    localparam int NL = 3;
    localparam int LN = 1;

    logic clk = 1'b0, rst_n = 1'b0;
    logic bit_tick = 1'b0, frame_sync = 1'b0, net_mode = 1'b0;
    logic rx_en = 1'b0, wr_en = 1'b0, clr_flags = 1'b0;
    logic [NL-1:0] tx_ctrl = '0;
    logic [W-1:0]  wr_data = '0;
    logic sd_out, sd_oe, rx_sel, tde, underrun, cfg_err;

    int n_chk = 0, n_fail = 0;
    int tick_cnt = 0, fper = W + 3;
    bit tick_ph = 1'b0, rnd = 1'b0;

    // reference model state
    int m_st = 0, m_cnt = 0;
    bit m_rs = 0, m_tde = 1, m_und = 0, m_cerr = 0;
    logic [W-1:0] m_sr = '0, m_hold = '0;
    bit b_te, b_last, b_ld;

    fsa_tx_lane #(.WORD_W(W), .NUM_LANES(NL), .LANE(LN), .SHARED_PIN(1'b1)) uut (
        .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .frame_sync(frame_sync),
        .net_mode(net_mode), .tx_ctrl(tx_ctrl), .rx_en(rx_en), .wr_en(wr_en),
        .wr_data(wr_data), .clr_flags(clr_flags), .sd_out(sd_out), .sd_oe(sd_oe),
        .rx_sel(rx_sel), .tde(tde), .underrun(underrun), .cfg_err(cfg_err)
    );

    always #2.5 clk = ~clk;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_cnt = 0; m_rs = 0; m_sr = '0; m_hold = '0;
            m_tde = 1; m_und = 0; m_cerr = 0;
        end else begin
            b_te   = tx_ctrl[LN];
            b_last = (m_cnt == W - 1);
            b_ld   = bit_tick && b_te && ((m_st == 1 && frame_sync) ||
                     (m_st == 2 && b_last && (frame_sync || (net_mode && !m_rs))));
            if (b_ld) m_sr <= m_tde ? '0 : m_hold;
            else if (bit_tick && m_st == 2) m_sr <= m_sr << 1;
            m_und  <= (m_und && !clr_flags) || (b_ld && m_tde);
            m_cerr <= (m_cerr && !clr_flags) || (b_te && rx_en);
            if (wr_en) begin m_hold <= wr_data; m_tde <= 0; end
            else if (b_ld) m_tde <= 1;
            m_rs <= (b_ld || m_st != 2) ? 1'b0 : (m_rs || !b_te);
            if (b_ld) m_cnt <= 0;
            else if (bit_tick && m_st == 2) m_cnt <= m_cnt + 1;
            case (m_st)
                0: if (b_te) m_st <= 1;
                1: if (!b_te) m_st <= 0; else if (bit_tick && frame_sync) m_st <= 2;
                default: if (bit_tick && b_last && !b_ld) m_st <= b_te ? 1 : 0;
            endcase
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic bit exp_rx();
        return !tx_ctrl[LN] && rx_en;
    endfunction

    task automatic cmp();
        chk(sd_oe === (m_st == 2), "R3 pin drive", sd_oe, m_st == 2);
        chk(sd_out === ((m_st == 2) ? m_sr[W-1] : 1'b0), "R4 serial bit", sd_out,
            (m_st == 2) ? m_sr[W-1] : 1'b0);
        chk(tde === m_tde, "R8 tde", tde, m_tde);
        chk(underrun === m_und, "R9 underrun", underrun, m_und);
        chk(rx_sel === exp_rx(), "R10 rx_sel", rx_sel, exp_rx());
        chk(cfg_err === m_cerr, "R11 cfg_err", cfg_err, m_cerr);
    endtask

    task automatic step();
        @(negedge clk);
        cmp();
        tick_ph  = !tick_ph;
        bit_tick = tick_ph;
        if (bit_tick) begin
            frame_sync = ((tick_cnt % fper) == 0);
            tick_cnt++;
        end else begin
            frame_sync = 1'b0;
        end
        wr_en = 1'b0;
        clr_flags = 1'b0;
        if (rnd) begin
            if ($urandom % 64 == 0) tx_ctrl[LN] = ~tx_ctrl[LN];
            if ($urandom % 64 == 0) rx_en = ~rx_en;
            if ($urandom % 100 == 0) tx_ctrl[0] = ~tx_ctrl[0];
            wr_en     = ($urandom % 12 == 0);
            wr_data   = W'($urandom);
            clr_flags = ($urandom % 40 == 0);
        end
    endtask

    task automatic wait_st(input int s);
        for (int i = 0; i < 3000 && m_st != s; i++) step();
        chk(m_st == s, "wait reached state", m_st, s);
    endtask

    task automatic write_word(input logic [W-1:0] d);
        wr_en = 1'b1;
        wr_data = d;
        step();
    endtask

    initial begin
        #(5.0 * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd20417));
        repeat (3) @(negedge clk);
        chk(sd_oe === 1'b0, "R1 reset sd_oe", sd_oe, 0);
        chk(sd_out === 1'b0, "R1 reset sd_out", sd_out, 0);
        chk(tde === 1'b1, "R1 reset tde", tde, 1);
        chk(underrun === 1'b0, "R1 reset underrun", underrun, 0);
        chk(cfg_err === 1'b0, "R1 reset cfg_err", cfg_err, 0);
        chk(rx_sel === 1'b0, "R1 reset rx_sel", rx_sel, 0);
        rst_n = 1'b1;

        // R2: other enable bits do nothing for this lane
        tx_ctrl = 3'b101;
        for (int i = 0; i < 60; i++) begin
            step();
            chk(sd_oe === 1'b0, "R2 foreign enable bit", sd_oe, 0);
        end

        // R6: write while disabled is held, never loaded
        tx_ctrl = '0;
        step();
        write_word(8'hA5);
        repeat (80) step();
        chk(tde === 1'b0, "R6 held data not taken", tde, 0);
        chk(sd_oe === 1'b0, "R6 pin floated", sd_oe, 0);

        // R3: enable waits for frame sync; R4/R8 word shifted out
        tx_ctrl[LN] = 1'b1;
        step();
        chk(sd_oe === 1'b0, "R3 armed before frame sync", sd_oe, 0);
        wait_st(2);
        step();
        chk(sd_out === 1'b1, "R4 first bit is MSB of A5", sd_out, 1);
        chk(tde === 1'b1, "R8 tde after load", tde, 1);

        // R5: clear enable mid-word
        write_word(8'h3C);
        wait_st(1);
        wait_st(2);
        while (m_cnt != 2) step();
        tx_ctrl[LN] = 1'b0;
        while (m_st == 2) begin
            chk(sd_oe === 1'b1, "R5 word finishes", sd_oe, 1);
            step();
        end
        step();
        chk(sd_oe === 1'b0, "R5 stopped after word", sd_oe, 0);

        // R9: underrun sends zeros
        tx_ctrl[LN] = 1'b1;
        wait_st(2);
        step();
        chk(underrun === 1'b1, "R9 underrun set", underrun, 1);
        chk(sd_out === 1'b0, "R9 zero word", sd_out, 0);
        clr_flags = 1'b1;
        step();
        step();
        chk(underrun === 1'b0, "R9 cleared", underrun, 0);
        tx_ctrl[LN] = 1'b0;
        wait_st(0);

        // R7: network mode restart silence, then back-to-back words
        net_mode = 1'b1;
        fper = 3 * W;
        write_word(8'h81);
        tx_ctrl[LN] = 1'b1;
        wait_st(2);
        while (m_cnt != 3) step();
        tx_ctrl[LN] = 1'b0;
        step();
        step();
        tx_ctrl[LN] = 1'b1;
        while (m_st == 2) step();
        step();
        while (m_st == 1) begin
            chk(sd_oe === 1'b0, "R7 silent until next frame", sd_oe, 0);
            step();
        end
        repeat (4 * W) begin
            step();
            chk(sd_oe === 1'b1, "R7 back-to-back slots", sd_oe, 1);
        end

        // R10 / R11: shared pin
        net_mode = 1'b0;
        tx_ctrl = '0;
        wait_st(0);
        rx_en = 1'b1;
        step();
        chk(rx_sel === 1'b1, "R10 receiver owns pin", rx_sel, 1);
        rx_en = 1'b0;
        step();
        chk(rx_sel === 1'b0, "R10 both clear rx_sel", rx_sel, 0);
        chk(sd_oe === 1'b0, "R10 both clear floated", sd_oe, 0);
        tx_ctrl[LN] = 1'b1;
        rx_en = 1'b1;
        step();
        step();
        chk(rx_sel === 1'b0, "R11 transmitter priority", rx_sel, 0);
        chk(cfg_err === 1'b1, "R11 cfg_err set", cfg_err, 1);
        rx_en = 1'b0;
        step();
        step();
        chk(cfg_err === 1'b1, "R11 cfg_err sticky", cfg_err, 1);
        clr_flags = 1'b1;
        step();
        step();
        chk(cfg_err === 1'b0, "R11 cfg_err cleared", cfg_err, 0);

        // random phases
        rnd = 1'b1;
        fper = W + 3;
        repeat (6000) step();
        net_mode = 1'b1;
        fper = 2 * W;
        repeat (6000) step();
        fper = 2 * W + 5;
        repeat (4000) step();
        rnd = 1'b0;
        step();

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule